// File: doc/BRIEF.md
# Bit-Flipping Scan Pattern Generator

This block produces scan stimulus for built-in self-test. A free-running linear feedback shift register supplies one pseudo-random bit per cycle to a scan chain, and a combinational flip function inverts selected bits on the way out. Random patterns that would detect nothing new are thereby bent into deterministic patterns aimed at hard-to-detect faults, without storing any seeds.

The flip function is a sum of cubes. Each cube is a ternary term with a care mask and a value over one vector made of the register state, the scan bit position and the pattern index. The flip is true when any cube matches. A run starts on a start pulse. It then shifts a fixed number of bits per pattern, spends one capture cycle after each pattern, and raises done once the configured number of patterns has been applied.

Top module: `bitflip_scan_gen`

## Requirements
- R1: While reset is applied, and until the first start, scan_en_o, capture_o, done_o and scan_out_o are all low.
- R2: A start pulse seen while idle or done makes scan_en_o high in the next cycle, with the bit position and the pattern index both at 0.
- R3: Each pattern is CHAIN_LEN cycles with scan_en_o high, followed by exactly one cycle with capture_o high and scan_en_o low.
- R4: The register steps only on shift cycles, as next = {^(state & TAPS), state[W-1:1]}. It holds during capture, idle and done, and it is never reseeded between patterns or between runs.
- R5: On a shift cycle, scan_out_o equals state[0] XOR flip. On every other cycle it is 0.
- R6: The flip is the OR, over the first N_CUBES cubes, of ((vec & mask) == (val & mask)). Here vec is {state, bit position, pattern index}, with the pattern index in the least significant bits, zero-extended to 32 bits. Cube i occupies bits [32i+31:32i] of CUBE_MASK and CUBE_VAL.
- R7: With N_CUBES = 0, scan_out_o on shift cycles is the plain register output state[0].
- R8: After the TEST_LEN-th capture cycle, done_o goes high, shifting stops, and done_o stays high until the next start.
- R9: A start pulse during a run has no effect on the output stream.
- R10: The register state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a run when idle or done |
| scan_out_o | output | 1 | Serial scan data |
| scan_en_o | output | 1 | High on shift cycles |
| capture_o | output | 1 | One-cycle capture strobe after each pattern |
| done_o | output | 1 | Run complete |

## Verification
The bench builds two copies with a 3-bit register (taps 011, period 7), a 5-bit chain and 6 patterns. One copy carries two cubes forming state[0]·(pattern[0] + bit[0]); the other has an empty cube list. Two back-to-back runs cover every bit of every pattern. This exercises both cube terms, the case where neither applies, continuation of the register across captures and across runs, and a start pulse injected in the middle of a run.

// File: rtl/bfsg_pkg.sv
package bfsg_pkg;
  localparam int CUBE_SLOTS = 8;
  localparam int CUBE_BITS  = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAP   = 2'd2,
    ST_DONE  = 2'd3
  } gen_state_e;
endpackage

// File: rtl/bfsg_lfsr.sv
module bfsg_lfsr #(
  parameter int             W    = 3,
  parameter logic [W-1:0]   TAPS = 3'b011,
  parameter logic [W-1:0]   SEED = 3'b001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (adv_i) state_d = {^(state_q & TAPS), state_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_q));
  a_r10_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/bfsg_ctrl.sv
module bfsg_ctrl
  import bfsg_pkg::*;
#(
  parameter int CHAIN_LEN = 5,
  parameter int TEST_LEN  = 6,
  parameter int BW        = 3,
  parameter int PW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          shift_o,
  output logic          capture_o,
  output logic          done_o,
  output logic [BW-1:0] bit_o,
  output logic [PW-1:0] pat_o
);
  localparam logic [BW-1:0] LAST_BIT = BW'(CHAIN_LEN - 1);
  localparam logic [PW-1:0] LAST_PAT = PW'(TEST_LEN - 1);

  gen_state_e    st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [PW-1:0] pat_q, pat_d;

  always_comb begin
    st_d  = st_q;
    bit_d = bit_q;
    pat_d = pat_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d  = ST_SHIFT;
          bit_d = '0;
          pat_d = '0;
        end
      end
      ST_SHIFT: begin
        if (bit_q == LAST_BIT) st_d = ST_CAP;
        else                   bit_d = bit_q + 1'b1;
      end
      ST_CAP: begin
        bit_d = '0;
        pat_d = pat_q + 1'b1;
        st_d  = (pat_q == LAST_PAT) ? ST_DONE : ST_SHIFT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      pat_q <= '0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      pat_q <= pat_d;
    end
  end

  assign shift_o   = (st_q == ST_SHIFT);
  assign capture_o = (st_q == ST_CAP);
  assign done_o    = (st_q == ST_DONE);
  assign bit_o     = bit_q;
  assign pat_o     = pat_q;

  a_r3_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_o, capture_o, done_o}));
  a_r3_capture_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> $past(shift_o && bit_q == LAST_BIT));
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_o && start_i && bit_q != LAST_BIT) |=> (shift_o && bit_q == $past(bit_q) + 1'b1));
endmodule

// File: rtl/bfsg_flip.sv
module bfsg_flip
  import bfsg_pkg::*;
#(
  parameter int                                VW        = 9,
  parameter int                                N_CUBES   = 2,
  parameter logic [CUBE_SLOTS*CUBE_BITS-1:0]   CUBE_MASK = '0,
  parameter logic [CUBE_SLOTS*CUBE_BITS-1:0]   CUBE_VAL  = '0
) (
  input  logic [VW-1:0] vec_i,
  output logic          flip_o
);
  logic [CUBE_BITS-1:0] vec_w;
  assign vec_w = CUBE_BITS'(vec_i);

  generate
    if (N_CUBES == 0) begin : g_none
      assign flip_o = 1'b0;
    end else begin : g_cubes
      logic [N_CUBES-1:0] hit;
      for (genvar i = 0; i < N_CUBES; i++) begin : g_term
        localparam logic [CUBE_BITS-1:0] M = CUBE_MASK[i*CUBE_BITS +: CUBE_BITS];
        localparam logic [CUBE_BITS-1:0] V = CUBE_VAL[i*CUBE_BITS +: CUBE_BITS];
        assign hit[i] = ((vec_w & M) == (V & M));
      end
      assign flip_o = |hit;
    end
  endgenerate
endmodule

// File: rtl/bitflip_scan_gen.sv
module bitflip_scan_gen
  import bfsg_pkg::*;
#(
  parameter int                              LFSR_W    = 3,
  parameter logic [LFSR_W-1:0]               TAPS      = 3'b011,
  parameter logic [LFSR_W-1:0]               SEED      = 3'b001,
  parameter int                              CHAIN_LEN = 5,
  parameter int                              TEST_LEN  = 6,
  parameter int                              N_CUBES   = 2,
  parameter logic [CUBE_SLOTS*CUBE_BITS-1:0] CUBE_MASK = {192'd0, 32'h48, 32'h41},
  parameter logic [CUBE_SLOTS*CUBE_BITS-1:0] CUBE_VAL  = {192'd0, 32'h48, 32'h41}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic scan_out_o,
  output logic scan_en_o,
  output logic capture_o,
  output logic done_o
);
  localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int PW = $clog2(TEST_LEN + 1);
  localparam int VW = LFSR_W + BW + PW;

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic              shift;
  logic [BW-1:0]     bit_pos;
  logic [PW-1:0]     pat_idx;
  logic [LFSR_W-1:0] lfsr_state;
  logic              flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  bfsg_ctrl #(.CHAIN_LEN(CHAIN_LEN), .TEST_LEN(TEST_LEN), .BW(BW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .start_i(start_i),
    .shift_o(shift), .capture_o(capture_o), .done_o(done_o),
    .bit_o(bit_pos), .pat_o(pat_idx)
  );

  bfsg_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_s), .adv_i(shift), .state_o(lfsr_state)
  );

  bfsg_flip #(.VW(VW), .N_CUBES(N_CUBES), .CUBE_MASK(CUBE_MASK), .CUBE_VAL(CUBE_VAL)) u_flip (
    .vec_i({lfsr_state, bit_pos, pat_idx}), .flip_o(flip)
  );

  assign scan_en_o  = shift;
  assign scan_out_o = shift & (lfsr_state[0] ^ flip);

  a_r5_quiet_off_shift: assert property (@(posedge clk) disable iff (!rst_s)
    !scan_en_o |-> !scan_out_o);
  a_r4_steps_on_shift: assert property (@(posedge clk) disable iff (!rst_s)
    scan_en_o |=> (lfsr_state[LFSR_W-2:0] == $past(lfsr_state[LFSR_W-1:1])));
endmodule

// File: tb/sim_bitflip_scan_gen.sv
`timescale 1ns/1ps
module sim_bitflip_scan_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic so0, se0, cap0, dn0;
  logic so1, se1, cap1, dn1;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  bitflip_scan_gen u0 (.clk(clk), .rst_n(rst_n), .start_i(start),
    .scan_out_o(so0), .scan_en_o(se0), .capture_o(cap0), .done_o(dn0));

  bitflip_scan_gen #(.N_CUBES(0)) u1 (.clk(clk), .rst_n(rst_n), .start_i(start),
    .scan_out_o(so1), .scan_en_o(se1), .capture_o(cap1), .done_o(dn1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] step(input logic [2:0] s);
    return {s[0] ^ s[1], s[2:1]};
  endfunction

  logic [2:0] m;

  task automatic run_once();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int p = 0; p < 6; p++) begin
      for (int b = 0; b < 5; b++) begin
        logic fl, exp0;
        fl   = m[0] & (p[0] | b[0]);          // R6 cube terms
        exp0 = m[0] ^ fl;
        check(se0 == 1'b1, "R2/R3 scan_en", se0, 1);
        check(so0 == exp0, "R5/R6 flipped bit", so0, exp0);
        check(so1 == m[0], "R7 plain stream", so1, m[0]);
        start = (p == 2 && b == 1);          // R9 mid-run start
        m = step(m);                          // R4
        @(negedge clk);
      end
      start = 1'b0;
      check(cap0 == 1'b1 && se0 == 1'b0, "R3 capture cycle", {cap0, se0}, 2);
      check(so0 == 1'b0, "R5 quiet on capture", so0, 0);
      @(negedge clk);
    end
    check(dn0 == 1'b1 && se0 == 1'b0, "R8 done", {dn0, se0}, 2);
    repeat (3) @(negedge clk);
    check(dn0 == 1'b1 && dn1 == 1'b1 && so0 == 1'b0, "R8 done holds", {dn0, dn1, so0}, 6);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    m = 3'b001;
    repeat (3) @(negedge clk);
    check({se0, cap0, dn0, so0} == 4'b0, "R1 reset outputs", {se0, cap0, dn0, so0}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({se0, cap0, dn0, so0} == 4'b0, "R1 idle outputs", {se0, cap0, dn0, so0}, 0);
    run_once();
    run_once();                              // R4 no reseed between runs
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule